// File: doc/BRIEF.md
# Router Power-Gating Handshake Controller

This controller sits beside one router of a mesh network-on-chip and decides when that router's power switch may be opened. It watches a flag from the router datapath that says no flits are held. When the router is idle and no neighbor is asking for service, the controller raises a gate-notice line toward each of its four neighbors. It then spends one cycle in a notice state before it asserts the sleep enable. A neighbor that has traffic for this router raises its wake request line. This starts a fixed-length wakeup. The gate-notice lines stay high for the whole wakeup and drop only when the router can accept flits again.

All pins are plain control and status signals. No data passes through the block, so it has no valid/ready interface. Neighbors treat a high gate-notice line as back-pressure: they hold every flit meant for this router until the line falls. The controller also measures each gated interval in cycles. It keeps a sticky flag that records whether any interval ended before the breakeven time, which is the shortest stay that pays back the energy spent on a gating cycle.

Top module: `pg_handshake_ctrl`

## Requirements
- R1: After reset the router is on: ready is 1, all gate-notice bits are 0, sleep enable is 0, the interval length output is 0 and the short flag is 0.
- R2: From the on state the controller moves to the notice state only on a cycle where the datapath-empty input is 1 and every wake request bit is 0. Otherwise it stays on.
- R3: Gate-notice is driven high to all four neighbors in every state except on. Sleep enable rises only after a cycle in which all four notice bits were already high.
- R4: In the notice state, any wake request bit or a datapath-empty of 0 returns the controller to on at the next edge. Sleep enable is never asserted in this case.
- R5: In the off state (sleep enable 1), a 1 on any single wake request bit starts the wakeup at the next edge.
- R6: The wakeup lasts exactly WAKE_CYC cycles (default 12). During it sleep enable and ready are 0, and wake request inputs have no effect on its length.
- R7: Ready is 1 exactly when all gate-notice bits are 0. Ready and sleep enable are never both 1.
- R8: When a wakeup starts, the interval length output takes the number of cycles that sleep enable was 1 in the interval just ended. It holds that value until the next wakeup.
- R9: The short flag becomes 1 when an interval ends with a length below BET_CYC (default 10). Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_empty | input | 1 | Router datapath holds no flits |
| nbr_wake | input | 4 | Wake request, one bit per neighbor |
| nbr_gate | output | 4 | Gate-notice toward each neighbor; neighbors hold flits while high |
| sleep_en | output | 1 | Enable to the power switch |
| rtr_ready | output | 1 | Router can accept and forward flits |
| gated_len | output | CNT_W | Cycles spent gated in the last finished interval |
| short_gate | output | 1 | Sticky: some interval ended below the breakeven time |

## Verification
Several corner cases are targeted. One is a wake request in the single notice cycle. A design that gated anyway would raise sleep enable with a neighbor already waiting. Another is a wake request on the very first gated cycle. This gives a length-1 interval, which catches off-by-one errors in the interval count and the short flag. Wake requests kept high through the wakeup check that the wakeup timer neither restarts nor ends early. Mixed random traffic lets intervals fall on both sides of the breakeven time, which exposes a flag that clears itself or a comparison that uses the wrong bound.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    PGS_ON    = 2'd0,
    PGS_DRAIN = 2'd1,
    PGS_OFF   = 2'd2,
    PGS_WAKE  = 2'd3
  } pgc_state_e;
endpackage

// File: rtl/pgc_fsm.sv
module pgc_fsm
  import pgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_empty,
  input  logic       wake_any,
  input  logic       wake_done,
  output pgc_state_e state_o
);
  pgc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PGS_ON:    if (dp_empty && !wake_any) st_d = PGS_DRAIN;
      PGS_DRAIN: st_d = (wake_any || !dp_empty) ? PGS_ON : PGS_OFF;
      PGS_OFF:   if (wake_any) st_d = PGS_WAKE;
      PGS_WAKE:  if (wake_done) st_d = PGS_ON;
      default:   st_d = PGS_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= PGS_ON;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  AST_DRAIN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PGS_DRAIN && (wake_any || !dp_empty)) |=> st_q == PGS_ON); // R4
  AST_WAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PGS_OFF && wake_any) |=> st_q == PGS_WAKE); // R5
  AST_STAY_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PGS_ON && !dp_empty) |=> st_q == PGS_ON); // R2
endmodule

// File: rtl/pgc_wake_timer.sv
module pgc_wake_timer #(
  parameter int WAKE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(WAKE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(WAKE_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= LAST); // R6
endmodule

// File: rtl/pgc_gate_meter.sv
module pgc_gate_meter #(
  parameter int CNT_W   = 16,
  parameter int BET_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gated,
  input  logic             end_evt,
  output logic [CNT_W-1:0] len_o,
  output logic             short_o
);
  localparam logic [CNT_W:0] BET_W = (CNT_W+1)'(BET_CYC);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   total;

  assign total = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      len_o   <= '0;
      short_o <= 1'b0;
    end else begin
      if (!gated || end_evt)  run_q <= '0;
      else if (run_q != CMAX) run_q <= run_q + 1'b1;
      if (gated && end_evt) begin
        len_o <= total[CNT_W] ? CMAX : total[CNT_W-1:0];
        if (total < BET_W) short_o <= 1'b1;
      end
    end
  end

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |=> short_o); // R9
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(gated && end_evt) |=> $stable(len_o)); // R8
endmodule

// File: rtl/pg_handshake_ctrl.sv
module pg_handshake_ctrl
  import pgc_pkg::*;
#(
  parameter int NUM_NBR  = 4,
  parameter int WAKE_CYC = 12,
  parameter int BET_CYC  = 10,
  parameter int CNT_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dp_empty,
  input  logic [NUM_NBR-1:0] nbr_wake,
  output logic [NUM_NBR-1:0] nbr_gate,
  output logic               sleep_en,
  output logic               rtr_ready,
  output logic [CNT_W-1:0]   gated_len,
  output logic               short_gate
);
  pgc_state_e st;
  logic wake_any, wake_done;

  assign wake_any = |nbr_wake;

  pgc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dp_empty(dp_empty),
    .wake_any(wake_any), .wake_done(wake_done), .state_o(st)
  );

  pgc_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == PGS_WAKE), .done(wake_done)
  );

  pgc_gate_meter #(.CNT_W(CNT_W), .BET_CYC(BET_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .gated(st == PGS_OFF), .end_evt(wake_any),
    .len_o(gated_len), .short_o(short_gate)
  );

  for (genvar i = 0; i < NUM_NBR; i++) begin : g_notice
    assign nbr_gate[i] = (st != PGS_ON);
  end

  assign sleep_en  = (st == PGS_OFF);
  assign rtr_ready = (st == PGS_ON);

  AST_SLEEP_AFTER_NOTICE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_en) |-> $past(&nbr_gate)); // R3
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rtr_ready && sleep_en)); // R7
  AST_WAKE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_en && wake_any) |=> !sleep_en && !rtr_ready); // R6
endmodule

// File: tb/tb_pg_handshake_ctrl.sv
module tb_pg_handshake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE = 12;
  localparam int BET  = 10;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_empty = 1'b0;
  logic [3:0] nbr_wake = '0;
  logic [3:0] nbr_gate;
  logic sleep_en, rtr_ready, short_gate;
  logic [CW-1:0] gated_len;

  pg_handshake_ctrl #(.WAKE_CYC(WAKE), .BET_CYC(BET), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .dp_empty(dp_empty), .nbr_wake(nbr_wake),
    .nbr_gate(nbr_gate), .sleep_en(sleep_en), .rtr_ready(rtr_ready),
    .gated_len(gated_len), .short_gate(short_gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  // reference model: 0 on, 1 notice, 2 off, 3 wakeup
  int m_st = 0, m_w = 0, m_g = 0, m_len = 0;
  bit m_short = 1'b0;

  function automatic int next_st(int s, bit emp, bit wk, int w);
    case (s)
      0: return (emp && !wk) ? 1 : 0;
      1: return (wk || !emp) ? 0 : 2;
      2: return wk ? 3 : 2;
      default: return (w == WAKE - 1) ? 0 : 3;
    endcase
  endfunction

  task automatic model_step(bit emp, bit wk);
    int ns;
    ns = next_st(m_st, emp, wk, m_w);
    if (m_st == 2 && wk) begin
      m_len = m_g + 1;
      if (m_g + 1 < BET) m_short = 1'b1;
    end
    m_g = (m_st == 2 && !wk) ? m_g + 1 : 0;
    m_w = (m_st == 3 && ns == 3) ? m_w + 1 : 0;
    m_st = ns;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R3 nbr_gate"}, int'(nbr_gate), (m_st != 0) ? 15 : 0);
    chk({ctx, " R6 sleep_en"}, int'(sleep_en), int'(m_st == 2));
    chk({ctx, " R7 rtr_ready"}, int'(rtr_ready), int'(m_st == 0));
    chk({ctx, " R8 gated_len"}, int'(gated_len), m_len);
    chk({ctx, " R9 short_gate"}, int'(short_gate), int'(m_short));
  endtask

  // drive at negedge, model at posedge, check at following negedge
  task automatic cyc(bit emp, logic [3:0] wk, string ctx);
    dp_empty = emp;
    nbr_wake = wk;
    @(posedge clk);
    model_step(emp, |wk);
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    // R2: busy datapath keeps router on
    repeat (4) cyc(1'b0, 4'h0, "R2 busy");
    cyc(1'b1, 4'h2, "R2 wake blocks drain");
    // R4: abort from notice by wake, then by busy
    cyc(1'b1, 4'h0, "R4 enter notice");
    cyc(1'b1, 4'h8, "R4 abort wake");
    cyc(1'b1, 4'h0, "R4 enter notice");
    cyc(1'b0, 4'h0, "R4 abort busy");
    // R5/R8/R9: length-1 interval
    cyc(1'b1, 4'h0, "R3 notice");
    cyc(1'b1, 4'h0, "R3 off");
    cyc(1'b1, 4'h1, "R5 wake bit0");
    // R6: wake held high throughout wakeup
    for (int i = 0; i < WAKE + 2; i++) cyc(1'b1, 4'hF, "R6 held wake");
    // long interval beyond breakeven, wake from bit 2
    cyc(1'b1, 4'h0, "R3 notice");
    for (int i = 0; i < 25; i++) cyc(1'b1, 4'h0, "R8 long off");
    cyc(1'b1, 4'h4, "R5 wake bit2");
    for (int i = 0; i < WAKE + 1; i++) cyc(1'b0, 4'h0, "R6 wakeup");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit e;
      logic [3:0] w;
      e = ($urandom % 8) != 0;
      w = (($urandom % 12) == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      cyc(e, w, "R2 random");
    end
    finished = 1'b1;
    summary();
  end
endmodule